// File: doc/BRIEF.md
# Fault Recording and Status Unit

This block sits beside an address translation engine and keeps a record of the faults that engine reports. Each fault report arrives as a one-cycle strobe with a payload. The unit stores the payload in a small bank of recording slots, each with its own valid bit. It also keeps a status word that software reads. That word shows whether any slot is pending, the index of the slot that held the first pending fault, a sticky overflow flag, and four sticky error flags. The engine raises those error flags through separate strobes.

Software works through a write-only register port. It clears status bits and slot valid bits by writing ones to them, and it can mask the fault-event output. The status word and every slot's contents are driven straight to the outputs. Once the slot bank is full, the overflow flag latches. From then on every new fault is dropped until software clears that flag.

Top module: `fault_rec_unit`

## Requirements
- R1: The status word has this layout: bit 0 is the overflow flag, bit 1 is the pending flag, bit 4 is the queue error, bit 5 is the completion error, bit 6 is the completion time-out, and bit 7 is the request overflow. Bits 15:8 hold the first-pending index. Bits 3:2 and 31:16 always read zero. After reset the whole word reads zero.
- R2: A fault that is accepted is stored in the lowest-numbered slot whose valid bit is clear. Its payload appears on that slot's data output, and its valid bit reads one from the cycle after the strobe.
- R3: A fault that arrives while all slots are valid and the overflow flag is clear sets the overflow flag. The fault is not stored and no valid bit changes.
- R4: While the overflow flag is set, fault strobes change no slot valid bit and no slot data. This holds even when free slots exist.
- R5: The pending flag equals the OR of all slot valid bits.
- R6: When a fault is stored while no slot is valid, the first-pending index is set to the index of the slot written. While the pending flag stays set, the index does not change.
- R7: A write to address 2 clears the valid bit of every slot i for which write-data bit i is one. Bits written as zero leave their slots unchanged.
- R8: Strobe bits 0..3 of the error input set status bits 4..7. Each of these bits is cleared only by a write to address 0 with a one in that bit position. A write to address 0 with a one in bit 0 clears the overflow flag.
- R9: When a hardware set and a software write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R10: The fault-event output is high for the one cycle after a fault is stored or after any error bit goes from clear to set. This happens only if the mask, which is bit 0 of the control register at address 1, was clear in the cycle of the cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fault_vld | input | 1 | Fault report strobe |
| fault_payload | input | PAYLOAD_W | Fault record contents |
| err_evt | input | 4 | Error strobes: queue, completion, time-out, request overflow |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 status, 1 control, 2 slot clear |
| wr_data | input | 32 | Register write data |
| status | output | 32 | Status word |
| slot_valid | output | NUM_SLOTS | Per-slot valid bits |
| slot_data | output | NUM_SLOTS*PAYLOAD_W | Slot payloads, slot 0 in the low bits |
| fault_evt | output | 1 | Fault-event request pulse |

## Verification
Directed sequences fill the bank in order and then overflow it. One sequence frees a middle slot while the overflow flag is set. This separates the "lowest free slot" rule from a fill pointer, and separates the blocking by the overflow flag from a check for a full bank. Strobing an error in the same cycle as its clear write shows which side wins. The mask is toggled around faults to check the event output. Seeded random mixes of faults, error strobes and clears then exercise partial occupancy, back-to-back rises of the pending flag and the latching of the index, and each result is compared against a bench model.

// File: rtl/fr_pkg.sv
// Shared definitions for the fault recording unit: register addresses
// and status bit positions. Assumes a 2-bit register address.
package fr_pkg;
    typedef enum logic [1:0] {
        A_STATUS  = 2'd0,
        A_CTRL    = 2'd1,
        A_SLOTCLR = 2'd2,
        A_SPARE   = 2'd3
    } fr_addr_e;

    localparam int ST_OVF     = 0;
    localparam int ST_PEND    = 1;
    localparam int ST_ERR_LO  = 4;
    localparam int ST_IDX_LO  = 8;
    localparam int NUM_ERR    = 4;
endpackage

// File: rtl/fr_slot_alloc.sv
// Picks the lowest-numbered free slot. Purely combinational.
// Assumes NUM_SLOTS >= 2 and IDX_W = $clog2(NUM_SLOTS).
module fr_slot_alloc #(
    parameter int NUM_SLOTS = 4,
    localparam int IDX_W = $clog2(NUM_SLOTS)
) (
    input  logic [NUM_SLOTS-1:0] valid,
    output logic                 any_free,
    output logic [IDX_W-1:0]     free_idx
);
    // Priority scan from the top so the lowest free index wins
    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                any_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/fr_slot_bank.sv
// Holds the recording slots: one payload register and one valid bit
// per slot. A record writes the selected slot and sets its valid bit;
// a clear mask drops valid bits. Assumes the slot being written is free,
// so a set and a clear never target the same slot.
module fr_slot_bank #(
    parameter int NUM_SLOTS = 4,
    parameter int PAYLOAD_W = 32,
    localparam int IDX_W = $clog2(NUM_SLOTS)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           rec,
    input  logic [IDX_W-1:0]               rec_idx,
    input  logic [PAYLOAD_W-1:0]           rec_data,
    input  logic [NUM_SLOTS-1:0]           clr_mask,
    output logic [NUM_SLOTS-1:0]           valid,
    output logic [NUM_SLOTS*PAYLOAD_W-1:0] data_flat
);
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic                 hit;
        logic [PAYLOAD_W-1:0] data_q;
        assign hit = rec && (rec_idx == IDX_W'(g));

        // Valid bit: a record sets it, software clear drops it, set wins
        always_ff @(posedge clk) begin
            if (!rst_n)             valid[g] <= 1'b0;
            else if (hit)           valid[g] <= 1'b1;
            else if (clr_mask[g])   valid[g] <= 1'b0;
        end

        // Payload register: loaded only when this slot is recorded
        always_ff @(posedge clk) begin
            if (!rst_n)   data_q <= '0;
            else if (hit) data_q <= rec_data;
        end

        assign data_flat[g*PAYLOAD_W +: PAYLOAD_W] = data_q;
    end
endmodule

// File: rtl/fr_status.sv
// Status and control state: sticky overflow, sticky error flags,
// the first-pending index, the event mask and the event pulse.
// Hardware sets win over same-cycle write-one-to-clear.
module fr_status #(
    parameter int NUM_SLOTS = 4,
    localparam int IDX_W = $clog2(NUM_SLOTS),
    localparam int NERR = fr_pkg::NUM_ERR
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rec,
    input  logic [IDX_W-1:0] rec_idx,
    input  logic             none_valid,
    input  logic             ovf_set,
    input  logic [NERR-1:0]  err_set,
    input  logic             ovf_clr,
    input  logic [NERR-1:0]  err_clr,
    input  logic             mask_wr,
    input  logic             mask_val,
    output logic             ovf,
    output logic [NERR-1:0]  err,
    output logic [7:0]       first_idx,
    output logic             evt
);
    logic            mask_q;
    logic [NERR-1:0] err_rise;

    assign err_rise = err_set & ~err;

    // Overflow flag: set on a dropped fault, cleared by software
    always_ff @(posedge clk) begin
        if (!rst_n)       ovf <= 1'b0;
        else if (ovf_set) ovf <= 1'b1;
        else if (ovf_clr) ovf <= 1'b0;
    end

    // Error flags: per-bit set by strobe, else per-bit software clear
    always_ff @(posedge clk) begin
        if (!rst_n) err <= '0;
        else        err <= err_set | (err & ~err_clr);
    end

    // First-pending index: latched when a record finds the bank empty
    always_ff @(posedge clk) begin
        if (!rst_n)                 first_idx <= '0;
        else if (rec && none_valid) first_idx <= 8'(rec_idx);
    end

    // Event mask from the control register
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= 1'b0;
        else if (mask_wr) mask_q <= mask_val;
    end

    // Event pulse: one cycle after a record or an error rise, if unmasked
    always_ff @(posedge clk) begin
        if (!rst_n) evt <= 1'b0;
        else        evt <= (rec || (|err_rise)) && !mask_q;
    end
endmodule

// File: rtl/fault_rec_unit.sv
// Top of the fault recording unit. Routes fault strobes to the slot
// bank when the overflow flag is clear and a slot is free, decodes the
// register write port and assembles the status word.
module fault_rec_unit #(
    parameter int NUM_SLOTS = 4,
    parameter int PAYLOAD_W = 32,
    localparam int IDX_W = $clog2(NUM_SLOTS),
    localparam int NERR = fr_pkg::NUM_ERR
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           fault_vld,
    input  logic [PAYLOAD_W-1:0]           fault_payload,
    input  logic [NERR-1:0]                err_evt,
    input  logic                           wr_en,
    input  logic [1:0]                     wr_addr,
    input  logic [31:0]                    wr_data,
    output logic [31:0]                    status,
    output logic [NUM_SLOTS-1:0]           slot_valid,
    output logic [NUM_SLOTS*PAYLOAD_W-1:0] slot_data,
    output logic                           fault_evt
);
    import fr_pkg::*;

    logic             any_free;
    logic [IDX_W-1:0] free_idx;
    logic             rec, ovf_set, ovf;
    logic [NERR-1:0]  err;
    logic [7:0]       first_idx;
    logic             wr_st, wr_ctl, wr_clr;
    logic [NUM_SLOTS-1:0] clr_mask;
    logic             unused_wdata;

    assign wr_st  = wr_en && (wr_addr == A_STATUS);
    assign wr_ctl = wr_en && (wr_addr == A_CTRL);
    assign wr_clr = wr_en && (wr_addr == A_SLOTCLR);
    assign clr_mask = wr_clr ? wr_data[NUM_SLOTS-1:0] : '0;
    assign unused_wdata = ^wr_data;

    assign rec     = fault_vld && !ovf && any_free;
    assign ovf_set = fault_vld && !ovf && !any_free;

    fr_slot_alloc #(.NUM_SLOTS(NUM_SLOTS)) u_alloc (
        .valid    (slot_valid),
        .any_free (any_free),
        .free_idx (free_idx)
    );

    fr_slot_bank #(.NUM_SLOTS(NUM_SLOTS), .PAYLOAD_W(PAYLOAD_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .rec       (rec),
        .rec_idx   (free_idx),
        .rec_data  (fault_payload),
        .clr_mask  (clr_mask),
        .valid     (slot_valid),
        .data_flat (slot_data)
    );

    fr_status #(.NUM_SLOTS(NUM_SLOTS)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .rec        (rec),
        .rec_idx    (free_idx),
        .none_valid (slot_valid == '0),
        .ovf_set    (ovf_set),
        .err_set    (err_evt),
        .ovf_clr    (wr_st && wr_data[ST_OVF]),
        .err_clr    (wr_st ? wr_data[ST_ERR_LO +: NERR] : '0),
        .mask_wr    (wr_ctl),
        .mask_val   (wr_data[0]),
        .ovf        (ovf),
        .err        (err),
        .first_idx  (first_idx),
        .evt        (fault_evt)
    );

    // Status word assembly; unassigned bits read zero
    always_comb begin
        status                     = '0;
        status[ST_OVF]             = ovf;
        status[ST_PEND]            = |slot_valid;
        status[ST_ERR_LO +: NERR]  = err;
        status[ST_IDX_LO +: 8]     = first_idx;
    end
endmodule

// File: rtl/fr_unit_chk.sv
// Assertion checker for fault_rec_unit, attached with bind below.
module fr_unit_chk #(
    parameter int NUM_SLOTS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 fault_vld,
    input logic [3:0]           err_evt,
    input logic                 wr_en,
    input logic [1:0]           wr_addr,
    input logic [31:0]          wr_data,
    input logic [31:0]          status,
    input logic [NUM_SLOTS-1:0] slot_valid,
    input logic                 fault_evt
);
    // R3: a fault into a full bank sets overflow
    p_full_sets_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_vld && !status[0] && (&slot_valid)) |=> status[0]);

    // R4: while overflow is set, no slot becomes newly valid
    p_ovf_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_vld && status[0]) |=> ((slot_valid & ~$past(slot_valid)) == '0));

    // R5: a fault accepted into a free slot makes the pending flag set
    p_rec_pends_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_vld && !status[0] && !(&slot_valid)) |=> status[1]);

    // R6: index holds while pending stays set
    p_idx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (status[1] && $past(status[1]) && $past(rst_n)) |-> $stable(status[15:8]));

    // R8: an error flag stays set without a clearing write
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (status[4] && !(wr_en && wr_addr == 2'd0)) |=> status[4]);

    // R9: a strobe beats a same-cycle clear
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_evt[0] |=> status[4]);

    // R10: an event pulse always has a cause one cycle earlier
    p_evt_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_evt && $past(rst_n)) |-> $past(fault_vld || (|err_evt)));
endmodule

bind fault_rec_unit fr_unit_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fault_vld  (fault_vld),
    .err_evt    (err_evt),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .status     (status),
    .slot_valid (slot_valid),
    .fault_evt  (fault_evt)
);

// File: tb/fault_rec_unit_tb.sv
module fault_rec_unit_tb;
    localparam int N  = 4;
    localparam int PW = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            fault_vld = 1'b0;
    logic [PW-1:0]   fault_payload = '0;
    logic [3:0]      err_evt = '0;
    logic            wr_en = 1'b0;
    logic [1:0]      wr_addr = '0;
    logic [31:0]     wr_data = '0;
    logic [31:0]     status;
    logic [N-1:0]    slot_valid;
    logic [N*PW-1:0] slot_data;
    logic            fault_evt;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // bench model
    logic [N-1:0]  m_valid = '0;
    logic [PW-1:0] m_data [N];
    logic          m_ovf = 0, m_mask = 0, m_evt = 0;
    logic [3:0]    m_err = '0;
    logic [7:0]    m_fri = '0;

    always #4 clk = ~clk;

    fault_rec_unit #(.NUM_SLOTS(N), .PAYLOAD_W(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .fault_vld(fault_vld),
        .fault_payload(fault_payload), .err_evt(err_evt), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .status(status),
        .slot_valid(slot_valid), .slot_data(slot_data), .fault_evt(fault_evt)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int lowest_free(logic [N-1:0] v);
        for (int i = N - 1; i >= 0; i--) ;
        for (int i = 0; i < N; i++) if (!v[i]) return i;
        return -1;
    endfunction

    // one cycle: drive, update model, sample after edge, compare
    task automatic step(logic f, logic [PW-1:0] pl, logic [3:0] e,
                        logic w, logic [1:0] a, logic [31:0] d);
        int idx;
        logic rec;
        logic [3:0] rise;
        @(negedge clk);
        fault_vld = f; fault_payload = pl; err_evt = e;
        wr_en = w; wr_addr = a; wr_data = d;
        idx  = lowest_free(m_valid);
        rec  = f && !m_ovf && (idx >= 0);
        rise = e & ~m_err;
        m_evt = (rec || (|rise)) && !m_mask;
        if (rec && m_valid == '0) m_fri = 8'(idx);
        if (w && a == 2'd2) m_valid = m_valid & ~d[N-1:0];
        if (rec) begin m_valid[idx] = 1'b1; m_data[idx] = pl; end
        if (f && !m_ovf && idx < 0) m_ovf = 1'b1;
        else if (w && a == 2'd0 && d[0]) m_ovf = 1'b0;
        m_err = e | (m_err & ~((w && a == 2'd0) ? d[7:4] : 4'h0));
        if (w && a == 2'd1) m_mask = d[0];
        @(posedge clk); #1;
        fault_vld = 0; err_evt = '0; wr_en = 0;
        chk("R2 valid", 64'(slot_valid), 64'(m_valid));
        for (int i = 0; i < N; i++)
            if (m_valid[i]) chk("R2 data", 64'(slot_data[i*PW +: PW]), 64'(m_data[i]));
        chk("R3 ovf", 64'(status[0]), 64'(m_ovf));
        chk("R5 pend", 64'(status[1]), 64'(|m_valid));
        if (|m_valid) chk("R6 idx", 64'(status[15:8]), 64'(m_fri));
        chk("R8 err", 64'(status[7:4]), 64'(m_err));
        chk("R10 evt", 64'(fault_evt), 64'(m_evt));
        chk("R1 zero", 64'({status[31:16], status[3:2]}), 64'(0));
    endtask

    initial begin
        for (int i = 0; i < N; i++) m_data[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset status", 64'(status), 64'(0));
        chk("R1 reset valid", 64'(slot_valid), 64'(0));
        chk("R10 reset evt", 64'(fault_evt), 64'(0));
        @(negedge clk); rst_n = 1'b1;

        // R2/R6: fill bank in order
        step(1, 32'hA0, 0, 0, 0, 0);
        step(1, 32'hA1, 0, 0, 0, 0);
        step(1, 32'hA2, 0, 0, 0, 0);
        step(1, 32'hA3, 0, 0, 0, 0);
        // R3: full bank overflows
        step(1, 32'hA4, 0, 0, 0, 0);
        chk("R3 dropped", 64'(slot_valid), 64'hF);
        // R7: clear slot 1 only
        step(0, 0, 0, 1, 2'd2, 32'h2);
        chk("R7 clear one", 64'(slot_valid), 64'hD);
        // R4: overflow still set blocks the free slot
        step(1, 32'hB0, 0, 0, 0, 0);
        chk("R4 blocked", 64'(slot_valid), 64'hD);
        step(0, 0, 0, 1, 2'd0, 32'h1);
        chk("R8 ovf clear", 64'(status[0]), 64'h0);
        // R2: lowest free slot is 1
        step(1, 32'hB1, 0, 0, 0, 0);
        chk("R2 slot1", 64'(slot_data[PW +: PW]), 64'hB1);
        // R9: set and clear in same cycle
        step(0, 0, 4'h1, 0, 0, 0);
        step(0, 0, 4'h1, 1, 2'd0, 32'h10);
        chk("R9 set wins", 64'(status[4]), 64'h1);
        step(0, 0, 0, 1, 2'd0, 32'h10);
        chk("R8 w1c", 64'(status[4]), 64'h0);
        // R10: masked event
        step(0, 0, 0, 1, 2'd2, 32'hF);
        step(0, 0, 0, 1, 2'd1, 32'h1);
        step(1, 32'hC0, 0, 0, 0, 0);
        chk("R10 masked", 64'(fault_evt), 64'h0);
        step(0, 0, 0, 1, 2'd1, 32'h0);
        step(1, 32'hC1, 4'h6, 0, 0, 0);
        chk("R10 unmasked", 64'(fault_evt), 64'h1);

        // seeded random mix
        void'($urandom(32'h5EED));
        for (int k = 0; k < 400; k++) begin
            logic f, w;
            logic [3:0] e;
            f = ($urandom % 2) == 0;
            e = 4'($urandom) & 4'($urandom) & 4'($urandom);
            w = ($urandom % 10) < 3;
            step(f, $urandom, e, w, 2'($urandom), $urandom);
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule